// File: doc/BRIEF.md
# External Interrupt Line Controller

The controller watches sixteen external interrupt lines. Each line takes its input from one of several general-purpose I/O ports. Line n always samples pin n of the port chosen for it. Every chosen pin passes through a two-stage synchroniser. A third register then holds the previous synchronised level, so the block can detect rising and falling transitions.

When a line sees an edge that it has enabled, its pending flag latches. Software can also set a pending flag directly through a trigger register, and clears a flag by writing one to it. The pending flags are combined with a per-line mask and grouped into seven interrupt request outputs:

- Lines 0 to 4 each have an output of their own.
- Lines 5 to 9 share one output.
- Lines 10 to 15 share another.

All configuration goes through a small synchronous register bus. The bus has a word address, a write strobe and 32-bit write data. Read data is combinational from the address.

Word address map:

| Address | Register |
|---------|----------|
| 0 | Mask |
| 1 | Rising-edge enable |
| 2 | Falling-edge enable |
| 3 | Software trigger (write only) |
| 4 | Pending |
| 5 to 8 | Port-select registers 0 to 3 |

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and all seven request outputs are 0.
- R2: A low-to-high transition on the selected pin of line n sets pending bit n, about three clock cycles later, only when bit n of the rising-enable register (address 1) is 1. A high-to-low transition on a line with only rising enable leaves its pending bit at 0.
- R3: A high-to-low transition sets pending bit n only when bit n of the falling-enable register (address 2) is 1. With both enables set, either edge sets the bit.
- R4: Writing the pending register (address 4) clears every bit written as 1 and leaves every bit written as 0 unchanged. Without such a write, a pending bit never clears.
- R5: Writing 1 to bit n of the software-trigger register (address 3) sets pending bit n on the next clock edge. This register always reads 0.
- R6: A line drives a request output only while its mask bit (address 0) is 1. Its pending flag still latches while the line is masked.
- R7: The port for line n is the 4-bit field at bits (n&3)*4+3:(n&3)*4 of port-select register n>>2, at address 5+(n>>2). Line n observes only input bit p*16+n of the pin bus, where p is that field.
- R8: A port-select value of NUM_PORTS or more gives the line a constant low input, so the line never sees an edge.
- R9: Request outputs irqOut[0] to irqOut[4] follow masked pending bits 0 to 4. irqOut[5] is the OR of masked bits 5 to 9, and irqOut[6] is the OR of masked bits 10 to 15.
- R10: When a hardware edge sets a pending bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R11: Bits 31:16 of every register read as 0, and unmapped addresses 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| portPins | input | NUM_PORTS*16 | Pin levels; bit p*16+n is pin n of port p |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| irqOut | output | 7 | Grouped interrupt request outputs |

## Verification
The bench starts an edge on a line in exactly the cycle in which a clear of that line's pending bit lands. A design that let the clear win would drop that event and read 0.

It moves a line to another port and toggles the same pin on the old port. A field decoded at the wrong offset would catch the wrong pin or miss the right one.

It also points a line at a port that does not exist and toggles every port. A design that wrapped the select value would latch a pending bit.

Other checks cover the following cases:
- A falling edge with only rising enable set; an edge-polarity swap would latch it.
- A zero written to the pending register; a clear-on-write design would erase it.
- A masked line; a design that gated the latch rather than the output would show no pending bit.
- A line at each group boundary; a misplaced group boundary would light the wrong output.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int LINES       = 16;
  localparam int SEL_W       = 4;
  localparam int LINES_PER_REG = 4;
  localparam int SEL_REGS    = LINES / LINES_PER_REG;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 32;
  localparam int INDIV       = 5;
  localparam int GROUP_A_END = 9;
  localparam int IRQ_W       = INDIV + 2;

  localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_RISE   = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_FALL   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_SWTRIG = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 4'd4;
  localparam int               ADDR_SEL0   = 5;

  typedef struct packed {
    logic [LINES-1:0] swSet;
    logic [LINES-1:0] pendClr;
  } strobe_t;
endpackage

// File: rtl/line_irq_regs.sv
module line_irq_regs
  import line_irq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic [LINES-1:0]        pendFlags,
  output logic [LINES-1:0]        maskBits,
  output logic [LINES-1:0]        riseEn,
  output logic [LINES-1:0]        fallEn,
  output logic [LINES*SEL_W-1:0]  portSel,
  output strobe_t                 strobes,
  output logic [DATA_W-1:0]       regRdData
);
  localparam int SEL_REG_W = LINES_PER_REG * SEL_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskBits <= '0;
      riseEn   <= '0;
      fallEn   <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_MASK) maskBits <= regWrData[LINES-1:0];
      if (regAddr == ADDR_RISE) riseEn   <= regWrData[LINES-1:0];
      if (regAddr == ADDR_FALL) fallEn   <= regWrData[LINES-1:0];
    end
  end

  for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_SEL0 + r);
    always_ff @(posedge clk) begin
      if (!rst_n)
        portSel[r*SEL_REG_W +: SEL_REG_W] <= '0;
      else if (regWrEn && regAddr == MY_ADDR)
        portSel[r*SEL_REG_W +: SEL_REG_W] <= regWrData[SEL_REG_W-1:0];
    end
  end

  always_comb begin
    strobes.swSet   = (regWrEn && regAddr == ADDR_SWTRIG) ? regWrData[LINES-1:0] : '0;
    strobes.pendClr = (regWrEn && regAddr == ADDR_PEND)   ? regWrData[LINES-1:0] : '0;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_MASK: regRdData[LINES-1:0] = maskBits;
      ADDR_RISE: regRdData[LINES-1:0] = riseEn;
      ADDR_FALL: regRdData[LINES-1:0] = fallEn;
      ADDR_PEND: regRdData[LINES-1:0] = pendFlags;
      default:   regRdData = '0;
    endcase
    for (int r = 0; r < SEL_REGS; r++) begin
      if (regAddr == ADDR_W'(ADDR_SEL0 + r))
        regRdData[SEL_REG_W-1:0] = portSel[r*SEL_REG_W +: SEL_REG_W];
    end
  end
endmodule

// File: rtl/line_irq_datapath.sv
module line_irq_datapath
  import line_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*LINES-1:0]  portPins,
  input  logic [LINES*SEL_W-1:0]      portSel,
  input  logic [LINES-1:0]            riseEn,
  input  logic [LINES-1:0]            fallEn,
  input  logic [LINES-1:0]            maskBits,
  input  strobe_t                     strobes,
  output logic [LINES-1:0]            pendFlags,
  output logic [IRQ_W-1:0]            irqOut
);
  logic [LINES-1:0] rawPin;
  logic [LINES-1:0] syncA, syncB, prevLvl;
  logic [LINES-1:0] hwSet, maskedPend;

  for (genvar n = 0; n < LINES; n++) begin : g_mux
    logic [SEL_W-1:0] sel;
    assign sel = portSel[n*SEL_W +: SEL_W];
    always_comb begin
      rawPin[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel == SEL_W'(p)) rawPin[n] = portPins[p*LINES + n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= rawPin;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  assign hwSet = (syncB & ~prevLvl & riseEn) | (~syncB & prevLvl & fallEn);

  always_ff @(posedge clk) begin
    if (!rst_n) pendFlags <= '0;
    else        pendFlags <= (pendFlags & ~strobes.pendClr) | hwSet | strobes.swSet;
  end

  assign maskedPend = pendFlags & maskBits;

  for (genvar i = 0; i < INDIV; i++) begin : g_indiv
    assign irqOut[i] = maskedPend[i];
  end
  assign irqOut[INDIV]   = |maskedPend[GROUP_A_END:INDIV];
  assign irqOut[INDIV+1] = |maskedPend[LINES-1:GROUP_A_END+1];
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*LINES-1:0]  portPins,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  output logic [IRQ_W-1:0]            irqOut
);
  logic [LINES-1:0]       maskBits, riseEn, fallEn, pendFlags;
  logic [LINES*SEL_W-1:0] portSel;
  strobe_t                strobes;

  line_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .pendFlags(pendFlags), .maskBits(maskBits),
    .riseEn(riseEn), .fallEn(fallEn), .portSel(portSel),
    .strobes(strobes), .regRdData(regRdData)
  );

  line_irq_datapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .portPins(portPins), .portSel(portSel),
    .riseEn(riseEn), .fallEn(fallEn), .maskBits(maskBits),
    .strobes(strobes), .pendFlags(pendFlags), .irqOut(irqOut)
  );
endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker
  import line_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [IRQ_W-1:0]  irqOut,
  input logic [LINES-1:0]  pendFlags,
  input logic [LINES-1:0]  maskBits
);
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskBits == '0) |-> (irqOut == '0)); // R6

  AST_SW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_SWTRIG) |=>
      ((pendFlags & $past(regWrData[LINES-1:0])) == $past(regWrData[LINES-1:0]))); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && regAddr == ADDR_PEND) |=>
      ((pendFlags & $past(pendFlags)) == $past(pendFlags))); // R4

  AST_SWTRIG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_SWTRIG) |-> (regRdData == '0)); // R5

  AST_GROUP_A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut[INDIV] |-> (|(pendFlags[GROUP_A_END:INDIV] & maskBits[GROUP_A_END:INDIV]))); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[DATA_W-1:LINES] == '0); // R11
endmodule

bind line_irq_ctrl line_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
  .pendFlags(pendFlags), .maskBits(maskBits)
);

// File: tb/line_irq_ctrl_bench.sv
module line_irq_ctrl_bench;
  localparam int NP = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP*16-1:0] portPins = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [6:0]  irqOut;
  int checks = 0;
  int errors = 0;

  line_irq_ctrl #(.NUM_PORTS(NP)) u_line_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .portPins(portPins), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    settle();
    wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0); wr(4'd4, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset register", d, 0);
    end
    check("R1 reset irq", {25'd0, irqOut}, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(4'd1, 32'h1); wr(4'd0, 32'h1);
    portPins[0] = 1'b1; settle();
    rd(4'd4, d); check("R2 rising edge sets", d, 32'h1);
    check("R2 irq line 0", {25'd0, irqOut}, 32'h1);
    wr(4'd4, 32'h1);
    portPins[0] = 1'b0; settle();
    rd(4'd4, d); check("R2 falling ignored with rise only", d, 0);
    cleanup();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(4'd2, 32'h0008); wr(4'd1, 32'h0010); wr(4'd2, 32'h0018);
    portPins[3] = 1'b1; settle();
    rd(4'd4, d); check("R3 rise ignored with fall only", d & 32'h8, 0);
    portPins[3] = 1'b0; settle();
    rd(4'd4, d); check("R3 falling edge sets", d, 32'h8);
    wr(4'd4, 32'hFFFF);
    portPins[4] = 1'b1; settle();
    rd(4'd4, d); check("R3 both: rise sets", d, 32'h10);
    wr(4'd4, 32'hFFFF);
    portPins[4] = 1'b0; settle();
    rd(4'd4, d); check("R3 both: fall sets", d, 32'h10);
    cleanup();
  endtask

  task automatic t_w1c_sw();
    logic [31:0] d;
    wr(4'd3, 32'h00F0);
    rd(4'd4, d); check("R5 software trigger sets", d, 32'h00F0);
    rd(4'd3, d); check("R5 trigger reads zero", d, 0);
    wr(4'd4, 32'h0010);
    rd(4'd4, d); check("R4 write one clears", d, 32'h00E0);
    wr(4'd4, 32'h0000);
    settle();
    rd(4'd4, d); check("R4 write zero keeps", d, 32'h00E0);
    cleanup();
  endtask

  task automatic t_mask_group();
    logic [31:0] d;
    wr(4'd3, 32'h0080);
    rd(4'd4, d); check("R6 pending latches while masked", d, 32'h0080);
    check("R6 masked line quiet", {25'd0, irqOut}, 0);
    wr(4'd0, 32'h0080);
    check("R9 line 7 on shared output 5", {25'd0, irqOut}, 32'h20);
    wr(4'd4, 32'hFFFF);
    wr(4'd0, 32'hFFFF);
    wr(4'd3, 32'h1000);
    check("R9 line 12 on shared output 6", {25'd0, irqOut}, 32'h40);
    wr(4'd4, 32'hFFFF);
    wr(4'd3, 32'h0204);
    check("R9 line 2 own and line 9 shared", {25'd0, irqOut}, 32'h24);
    wr(4'd4, 32'hFFFF);
    wr(4'd3, 32'h0400);
    check("R9 line 10 on output 6", {25'd0, irqOut}, 32'h40);
    cleanup();
  endtask

  task automatic t_portsel();
    logic [31:0] d;
    wr(4'd6, 32'h200);
    rd(4'd6, d); check("R7 port select readback", d, 32'h200);
    wr(4'd1, 32'h0060);
    portPins[0*16+6] = 1'b1; settle();
    rd(4'd4, d); check("R7 old port pin ignored", d, 0);
    portPins[2*16+5] = 1'b1; settle();
    rd(4'd4, d); check("R7 other line unaffected", d, 0);
    portPins[2*16+6] = 1'b1; settle();
    rd(4'd4, d); check("R7 selected port pin sets", d, 32'h40);
    cleanup();
    portPins = '0; settle();
    wr(4'd4, 32'hFFFF);
    wr(4'd6, 0);
  endtask

  task automatic t_absent();
    logic [31:0] d;
    wr(4'd7, 32'h70);
    wr(4'd1, 32'h200); wr(4'd2, 32'h200);
    for (int p = 0; p < NP; p++) portPins[p*16+9] = 1'b1;
    settle();
    for (int p = 0; p < NP; p++) portPins[p*16+9] = 1'b0;
    settle();
    rd(4'd4, d); check("R8 absent port never edges", d, 0);
    cleanup();
    wr(4'd7, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(4'd1, 32'h2);
    portPins[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(4'd4, 32'h2);
    rd(4'd4, d); check("R10 edge beats clear", d, 32'h2);
    portPins[1] = 1'b0;
    cleanup();
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(4'd0, 32'hFFFFFFFF);
    rd(4'd0, d); check("R11 mask upper bits zero", d, 32'h0000FFFF);
    wr(4'd8, 32'hFFFFFFFF);
    rd(4'd8, d); check("R11 port select upper bits zero", d, 32'h0000FFFF);
    wr(4'd12, 32'hFFFFFFFF);
    rd(4'd12, d); check("R11 unmapped reads zero", d, 0);
    wr(4'd8, 0); wr(4'd0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_rise();
    t_fall();
    t_w1c_sw();
    t_mask_group();
    t_portsel();
    t_absent();
    t_set_wins();
    t_upper();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule